// File: doc/BRIEF.md
# Instruction-Driven Arithmetic Shifter and Normaliser

This block is a 16-bit shifter steered by a 4-bit operation code. It keeps two 4-bit shift-amount registers, called A and B here. It can arithmetic-shift a data word right by an amount taken from a shift-value input or from either register. It can also normalise a word. For that, a priority encoder counts the redundant sign bits, and the word is shifted left by that count. The count can go out on the shift-value output and can be stored back into one of the registers.

The data path from `dataIn` to `dataOut` is combinational in the default build. Only the two amount registers hold state. A register write therefore affects shifts issued from the next cycle on. The parameter `REG_OUT` adds a register stage on `dataOut` when set to 1. The shift-value line is modelled as a separate input and output plus a drive flag, not as a tristate pin. Opcodes 0 to 7 belong to a neighbouring unit. This block passes the data through unchanged for those codes.

Top module: `shift_norm_unit`

## Requirements
- R1: After a synchronous active-high `rst`, both amount registers hold 0, so opcodes 0xB and 0xC pass data through unshifted until a register is written.
- R2: Opcode 0x8 stores `svIn` into register A on the clock edge that ends the cycle, and `dataOut` equals `dataIn` during that cycle.
- R3: Opcode 0x9 stores `svIn` into register B on the clock edge that ends the cycle, and `dataOut` equals `dataIn` during that cycle.
- R4: Opcode 0xA shifts `dataIn` right by `svIn` (0 to 15) places. Low bits are dropped and the vacated high bits are filled with copies of bit 15.
- R5: Opcodes 0xB and 0xC perform the same arithmetic right shift by the value held in register A and in register B respectively.
- R6: Opcode 0xD shifts `dataIn` left by the normalisation count and fills with zeros. The count is the number of bits below bit 15 that equal bit 15, counted from bit 14 down to the first differing bit, and is therefore 15 for all-zero or all-one input.
- R7: `svDrive` is 1 and `svOut` carries the normalisation count only while the opcode is 0xD, 0xE or 0xF and `svOeN` is 0. Otherwise `svDrive` is 0 and `svOut` is 0.
- R8: Opcodes 0xE and 0xF normalise exactly as 0xD does, and also store the count into register A (0xE) or register B (0xF) at the end of the cycle.
- R9: Opcodes 0x0 to 0x7 pass `dataIn` through unchanged and leave both registers unchanged.
- R10: A shift in the same cycle as a register write uses the old register value, and the new value applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 16 | Word to be shifted |
| opCode | input | 4 | Operation select |
| svIn | input | 4 | Shift amount, or the value loaded into a register |
| svOeN | input | 1 | Active-low enable for driving the count out |
| dataOut | output | 16 | Shifted word |
| svOut | output | 4 | Normalisation count when driven, else 0 |
| svDrive | output | 1 | High while `svOut` is being driven |

## Verification
The hardest case to reach is a register value written by the encoder rather than from `svIn`. The bench observes it only through a later right shift. It issues 0xE or 0xF on a word with a known count, then a 0xB or 0xC shift of 0x8000 or 0x4000, so the stored count appears as the number of sign-fill bits. To show R10, a register load is placed directly before a shift that reads it. A low-opcode cycle then separates two register reads, which shows that the registers are unchanged.

// File: rtl/shift_norm_pkg.sv
package shift_norm_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SV   = 2'd1,
    SRC_RA   = 2'd2,
    SRC_RB   = 2'd3
  } amtSrc_e;

  typedef struct packed {
    amtSrc_e amtSrc;
    logic    doNorm;
    logic    loadA;
    logic    loadB;
    logic    loadFromCnt;
    logic    driveSv;
  } strobes_t;

  localparam logic [3:0] OP_LOAD_A  = 4'h8;
  localparam logic [3:0] OP_LOAD_B  = 4'h9;
  localparam logic [3:0] OP_ASR_SV  = 4'hA;
  localparam logic [3:0] OP_ASR_A   = 4'hB;
  localparam logic [3:0] OP_ASR_B   = 4'hC;
  localparam logic [3:0] OP_NORM    = 4'hD;
  localparam logic [3:0] OP_NORM_A  = 4'hE;
  localparam logic [3:0] OP_NORM_B  = 4'hF;

endpackage

// File: rtl/shift_norm_ctrl.sv
module shift_norm_ctrl
  import shift_norm_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic       svOeN,
  output strobes_t   strb
);

  always_comb begin
    strb = '0;
    strb.amtSrc = SRC_NONE;
    unique case (opCode)
      OP_LOAD_A: strb.loadA = 1'b1;
      OP_LOAD_B: strb.loadB = 1'b1;
      OP_ASR_SV: strb.amtSrc = SRC_SV;
      OP_ASR_A:  strb.amtSrc = SRC_RA;
      OP_ASR_B:  strb.amtSrc = SRC_RB;
      OP_NORM: begin
        strb.doNorm  = 1'b1;
        strb.driveSv = ~svOeN;
      end
      OP_NORM_A: begin
        strb.doNorm      = 1'b1;
        strb.loadA       = 1'b1;
        strb.loadFromCnt = 1'b1;
        strb.driveSv     = ~svOeN;
      end
      OP_NORM_B: begin
        strb.doNorm      = 1'b1;
        strb.loadB       = 1'b1;
        strb.loadFromCnt = 1'b1;
        strb.driveSv     = ~svOeN;
      end
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/shift_norm_dp.sv
module shift_norm_dp
  import shift_norm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  strobes_t                    strb,
  input  logic [DATA_W-1:0]           dataIn,
  input  logic [$clog2(DATA_W)-1:0]   svIn,
  output logic [DATA_W-1:0]           dataOut,
  output logic [$clog2(DATA_W)-1:0]   svOut,
  output logic                        svDrive
);

  localparam int AMT_W = $clog2(DATA_W);

  logic [AMT_W-1:0]  regA, regB, normCnt, shiftAmt, loadVal;
  logic [DATA_W-1:0] shiftRes;
  logic              hitEdge;

  // Priority encoder: sign-matching bits below the MSB
  always_comb begin
    normCnt = '0;
    hitEdge = 1'b0;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (!hitEdge && (dataIn[i] == dataIn[DATA_W-1]))
        normCnt = normCnt + 1'b1;
      else
        hitEdge = 1'b1;
    end
  end

  always_comb begin
    unique case (strb.amtSrc)
      SRC_SV:  shiftAmt = svIn;
      SRC_RA:  shiftAmt = regA;
      SRC_RB:  shiftAmt = regB;
      default: shiftAmt = '0;
    endcase
  end

  always_comb begin
    if (strb.doNorm)
      shiftRes = dataIn << normCnt;
    else
      shiftRes = DATA_W'($signed(dataIn) >>> shiftAmt);
  end

  assign loadVal = strb.loadFromCnt ? normCnt : svIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (strb.loadA) regA <= loadVal;
      if (strb.loadB) regB <= loadVal;
    end
  end

  generate
    if (REG_OUT) begin : g_outReg
      always_ff @(posedge clk) begin
        if (rst) dataOut <= '0;
        else     dataOut <= shiftRes;
      end
    end else begin : g_outComb
      assign dataOut = shiftRes;
    end
  endgenerate

  assign svDrive = strb.driveSv;
  assign svOut   = strb.driveSv ? normCnt : '0;

  AST_RESET_REGS: assert property (@(posedge clk)
    rst |=> (regA == '0) && (regB == '0)); // R1

  AST_LOAD_A_SV: assert property (@(posedge clk) disable iff (rst)
    (strb.loadA && !strb.loadFromCnt) |=> regA == $past(svIn)); // R2

  AST_LOAD_B_SV: assert property (@(posedge clk) disable iff (rst)
    (strb.loadB && !strb.loadFromCnt) |=> regB == $past(svIn)); // R3

  AST_NORM_SIGN_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (strb.doNorm && (dataIn != '0) && (dataIn != '1))
      |-> shiftRes[DATA_W-1] != shiftRes[DATA_W-2]); // R6

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strb.loadA && !strb.loadB) |=> $stable(regA) && $stable(regB)); // R9

endmodule

// File: rtl/shift_norm_unit.sv
module shift_norm_unit
  import shift_norm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DATA_W-1:0]         dataIn,
  input  logic [3:0]                opCode,
  input  logic [$clog2(DATA_W)-1:0] svIn,
  input  logic                      svOeN,
  output logic [DATA_W-1:0]         dataOut,
  output logic [$clog2(DATA_W)-1:0] svOut,
  output logic                      svDrive
);

  strobes_t strb;

  shift_norm_ctrl u_ctrl (
    .opCode (opCode),
    .svOeN  (svOeN),
    .strb   (strb)
  );

  shift_norm_dp #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .dataIn  (dataIn),
    .svIn    (svIn),
    .dataOut (dataOut),
    .svOut   (svOut),
    .svDrive (svDrive)
  );

  AST_SV_DRIVE_GATE: assert property (@(posedge clk) disable iff (rst)
    svDrive |-> (!svOeN && (opCode >= OP_NORM))); // R7

  AST_SV_QUIET: assert property (@(posedge clk) disable iff (rst)
    !svDrive |-> (svOut == '0)); // R7

endmodule

// File: tb/shift_norm_unit_bench.sv
module shift_norm_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] dataIn = '0;
  logic [3:0]  opCode = '0;
  logic [3:0]  svIn = '0;
  logic        svOeN = 1'b1;
  logic [15:0] dataOut;
  logic [3:0]  svOut;
  logic        svDrive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shift_norm_unit u_shift_norm_unit (
    .clk(clk), .rst(rst), .dataIn(dataIn), .opCode(opCode), .svIn(svIn),
    .svOeN(svOeN), .dataOut(dataOut), .svOut(svOut), .svDrive(svDrive)
  );

  // {req, op, sv, oeN, din, expOut, expSv, expDrv}
  localparam int NV = 21;
  localparam logic [49:0] VEC [NV] = '{
    {4'd1,  4'hB, 4'h0, 1'b1, 16'h8000, 16'h8000, 4'h0, 1'b0}, // R1
    {4'd2,  4'h8, 4'h4, 1'b1, 16'h1234, 16'h1234, 4'h0, 1'b0}, // R2 A<=4
    {4'd10, 4'hB, 4'h0, 1'b1, 16'h8000, 16'hF800, 4'h0, 1'b0}, // R10
    {4'd3,  4'h9, 4'h3, 1'b1, 16'hABCD, 16'hABCD, 4'h0, 1'b0}, // R3 B<=3
    {4'd5,  4'hC, 4'h0, 1'b1, 16'h7FF0, 16'h0FFE, 4'h0, 1'b0}, // R5
    {4'd4,  4'hA, 4'hF, 1'b1, 16'h8000, 16'hFFFF, 4'h0, 1'b0}, // R4
    {4'd4,  4'hA, 4'h1, 1'b1, 16'h4000, 16'h2000, 4'h0, 1'b0}, // R4
    {4'd4,  4'hA, 4'h0, 1'b1, 16'h9999, 16'h9999, 4'h0, 1'b0}, // R4
    {4'd6,  4'hD, 4'h0, 1'b0, 16'h0010, 16'h4000, 4'hA, 1'b1}, // R6
    {4'd7,  4'hD, 4'h0, 1'b1, 16'hFF00, 16'h8000, 4'h0, 1'b0}, // R7
    {4'd6,  4'hD, 4'h0, 1'b0, 16'h0000, 16'h0000, 4'hF, 1'b1}, // R6
    {4'd6,  4'hD, 4'h0, 1'b0, 16'hFFFF, 16'h8000, 4'hF, 1'b1}, // R6
    {4'd6,  4'hD, 4'h0, 1'b0, 16'h4000, 16'h4000, 4'h0, 1'b1}, // R6
    {4'd8,  4'hE, 4'h0, 1'b0, 16'h0100, 16'h4000, 4'h6, 1'b1}, // R8 A<=6
    {4'd8,  4'hB, 4'h0, 1'b0, 16'h4000, 16'h0100, 4'h0, 1'b0}, // R8
    {4'd8,  4'hF, 4'h0, 1'b1, 16'hE000, 16'h8000, 4'h0, 1'b0}, // R8 B<=2
    {4'd8,  4'hC, 4'h0, 1'b1, 16'h8000, 16'hE000, 4'h0, 1'b0}, // R8
    {4'd9,  4'h3, 4'h9, 1'b1, 16'h5555, 16'h5555, 4'h0, 1'b0}, // R9
    {4'd9,  4'hB, 4'h0, 1'b1, 16'h8000, 16'hFE00, 4'h0, 1'b0}, // R9
    {4'd9,  4'hC, 4'h0, 1'b1, 16'h8000, 16'hE000, 4'h0, 1'b0}, // R9
    {4'd7,  4'h0, 4'h0, 1'b0, 16'h1111, 16'h1111, 4'h0, 1'b0}  // R7 R9
  };

  task automatic check(input int req, input logic [15:0] expOut,
                       input logic [3:0] expSv, input logic expDrv);
    checks++;
    if (dataOut !== expOut || svOut !== expSv || svDrive !== expDrv) begin
      errors++;
      $display("FAIL R%0d: out=%h sv=%h drv=%b expected out=%h sv=%h drv=%b",
               req, dataOut, svOut, svDrive, expOut, expSv, expDrv);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [3:0] sv,
                       input logic oeN, input logic [15:0] din);
    @(negedge clk);
    opCode = op; svIn = sv; svOeN = oeN; dataIn = din;
    #5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][45:42], VEC[i][41:38], VEC[i][37], VEC[i][36:21]);
      check(int'(VEC[i][49:46]), VEC[i][20:5], VEC[i][4:1], VEC[i][0]);
    end
    // R1: reset mid-run clears both registers
    apply(4'h0, 4'h0, 1'b1, 16'h0);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    apply(4'hB, 4'h0, 1'b1, 16'h8000);
    check(1, 16'h8000, 4'h0, 1'b0);
    apply(4'hC, 4'h0, 1'b1, 16'h8000);
    check(1, 16'h8000, 4'h0, 1'b0);
    // R10: load then use back to back; same cycle still sees old value
    apply(4'h9, 4'hF, 1'b1, 16'h8000);
    check(3, 16'h8000, 4'h0, 1'b0);
    apply(4'hC, 4'h0, 1'b1, 16'h8000);
    check(10, 16'hFFFF, 4'h0, 1'b0);
    // R2: max amount via register A
    apply(4'h8, 4'hF, 1'b1, 16'h7FFF);
    check(2, 16'h7FFF, 4'h0, 1'b0);
    apply(4'hB, 4'h0, 1'b1, 16'h7FFF);
    check(2, 16'h0000, 4'h0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule